// File: doc/BRIEF.md
# Packed Shift and Precision-Reduce Unit

This unit performs the narrowing and realignment steps of a packed-integer datapath. Two 32-bit operands, a 5-bit immediate shift amount and a 4-bit opcode enter together with a valid strobe. One cycle later the unit presents a registered 32-bit result with a matching valid strobe.

The shift operations split operand B into lanes. One form uses four signed bytes with an arithmetic right shift and optional round-half-up. The other uses two unsigned halfwords with a logical right shift. Each shift count comes either from the immediate or from the low bits of operand A.

The precision-reduce operation shifts each whole operand arithmetically and keeps the low halfword of each. The merge operations do four things: repack bytes taken from halfwords, align a byte stream across the two words, append low bits of A under B, and prepend low bits of A above B.

Top module: `pshift_unit`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge and `result` carries the operation's value. When `in_valid` is low at an edge, `out_valid` is low after it. Back-to-back valid cycles each produce their own result.
- R2: While `rst_n` is low, `out_valid` and `result` are zero. While `in_valid` is low, `result` keeps its last value.
- R3: Opcode 0 shifts each signed byte lane of B right arithmetically by `shamt[2:0]`. Opcode 2 does the same using `a[2:0]` as the count, ignoring the other bits of A. A count of zero returns B unchanged.
- R4: Opcodes 1 and 3 are the rounding forms of opcodes 0 and 2. For a nonzero count s, a lane whose original bit s-1 is one gets one added after the shift. The addition is modulo 256.
- R5: Opcode 4 shifts each unsigned halfword lane of B right logically by `shamt[3:0]`. Opcode 5 uses `a[3:0]` as the count. Vacated bits are zero.
- R6: Opcode 6 shifts A and B each right arithmetically as 32-bit signed words by `shamt`. The result is {A'[15:0], B'[15:0]}. Opcode 7 adds the same round-half-up as R4 to each word before packing, with a count of zero leaving the word unrounded.
- R7: Opcode 8 returns {A[23:16], A[7:0], B[23:16], B[7:0]}.
- R8: Opcode 9 aligns using p = `shamt[1:0]`. When p is 0 it returns B. Otherwise it returns (B << 8p) | (A >> 8(4-p)).
- R9: Opcode 10 with s = `shamt` returns (B << s) with its low s bits filled by the low s bits of A. With s = 0 it returns B.
- R10: Opcode 11 with s = `shamt` returns B when s is 0. Otherwise it returns (A << (32-s)) | (B >> s).
- R11: Opcodes 12 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Opcode |
| a | input | 32 | Operand A (also the register shift source) |
| b | input | 32 | Operand B |
| shamt | input | 5 | Immediate shift amount or position |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Registered result |

## Verification
The block keeps state in only two places: the result register and the valid flag. A wrong valid flag shows at `out_valid` on the edge right after the stimulus. A stale or wrongly enabled result register shows as a changed `result` during idle cycles. A fault in a lane shifter, rounding tap or merge shows as wrong bytes on `result` one cycle after the operation is issued. The vectors are chosen so that each lane carries a different sign and rounding bit, which keeps such faults from cancelling out.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  typedef enum logic [3:0] {
    OP_BSRA       = 4'd0,
    OP_BSRA_RND   = 4'd1,
    OP_BSRAV      = 4'd2,
    OP_BSRAV_RND  = 4'd3,
    OP_HSRL       = 4'd4,
    OP_HSRLV      = 4'd5,
    OP_PACK       = 4'd6,
    OP_PACK_RND   = 4'd7,
    OP_REPACK     = 4'd8,
    OP_ALIGN      = 4'd9,
    OP_APPEND     = 4'd10,
    OP_PREPEND    = 4'd11
  } shop_e;
endpackage

// File: rtl/pshift_lanes.sv
// Lane-parallel right shifter with optional round-half-up.
module pshift_lanes #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter bit ARITH  = 1'b1,
  parameter int SH_W   = $clog2(LANE_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [SH_W-1:0]   shift,
  input  logic              round_en,
  output logic [DATA_W-1:0] data_out
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_in;
    logic [LANE_W-1:0] shifted;
    logic [SH_W-1:0]   tap_idx;
    logic              rnd_bit;

    assign lane_in = data[g*LANE_W +: LANE_W];
    assign tap_idx = shift - 1'b1;

    if (ARITH) begin : g_arith
      assign shifted = LANE_W'($signed(lane_in) >>> shift);
    end else begin : g_logic
      assign shifted = lane_in >> shift;
    end

    always_comb begin
      rnd_bit = 1'b0;
      if (round_en && (shift != '0)) begin
        rnd_bit = lane_in[tap_idx];
      end
    end

    assign data_out[g*LANE_W +: LANE_W] = shifted + {{(LANE_W-1){1'b0}}, rnd_bit};
  end
endmodule

// File: rtl/pshift_merge.sv
// Repack, byte-align, append and prepend of two words.
module pshift_merge #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int SH_W   = $clog2(WORD_W),
  parameter int POS_W  = $clog2(WORD_W / BYTE_W)
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [SH_W-1:0]   amt,
  output logic [WORD_W-1:0] repack_out,
  output logic [WORD_W-1:0] align_out,
  output logic [WORD_W-1:0] append_out,
  output logic [WORD_W-1:0] prepend_out
);
  localparam int BYTES  = WORD_W / BYTE_W;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int HALVES = WORD_W / HALF_W;

  // low byte of every halfword: A fills the upper half, B the lower
  for (genvar h = 0; h < HALVES; h++) begin : g_repack
    assign repack_out[WORD_W/2 + h*BYTE_W +: BYTE_W] = a[h*HALF_W +: BYTE_W];
    assign repack_out[h*BYTE_W +: BYTE_W]            = b[h*HALF_W +: BYTE_W];
  end

  logic [POS_W-1:0]  pos;
  logic [WORD_W-1:0] low_mask;

  assign pos      = amt[POS_W-1:0];
  assign low_mask = ~({WORD_W{1'b1}} << amt);

  always_comb begin
    if (pos == '0) begin
      align_out = b;
    end else begin
      align_out = (b << (BYTE_W * int'(pos))) | (a >> (BYTE_W * (BYTES - int'(pos))));
    end
  end

  assign append_out = (b << amt) | (a & low_mask);

  always_comb begin
    if (amt == '0) begin
      prepend_out = b;
    end else begin
      prepend_out = (a << (WORD_W - int'(amt))) | (b >> amt);
    end
  end
endmodule

// File: rtl/pshift_unit.sv
module pshift_unit
  import pshift_pkg::*;
#(
  parameter int SHAMT_W = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [3:0]         op,
  input  logic [WORD_W-1:0]  a,
  input  logic [WORD_W-1:0]  b,
  input  logic [SHAMT_W-1:0] shamt,
  output logic               out_valid,
  output logic [WORD_W-1:0]  result
);
  localparam int BSH_W = $clog2(BYTE_W);
  localparam int HSH_W = $clog2(HALF_W);

  logic [BSH_W-1:0]    byte_sh;
  logic [HSH_W-1:0]    half_sh;
  logic                byte_rnd;
  logic [WORD_W-1:0]   byte_res;
  logic [WORD_W-1:0]   half_res;
  logic [2*WORD_W-1:0] word_res;
  logic [WORD_W-1:0]   repack_res, align_res, append_res, prepend_res;
  logic [WORD_W-1:0]   result_d;
  logic [WORD_W-1:0]   result_q;
  logic                valid_q;

  // shift count: immediate or low bits of operand A
  assign byte_sh  = (op == OP_BSRAV || op == OP_BSRAV_RND) ? a[BSH_W-1:0] : shamt[BSH_W-1:0];
  assign half_sh  = (op == OP_HSRLV) ? a[HSH_W-1:0] : shamt[HSH_W-1:0];
  assign byte_rnd = (op == OP_BSRA_RND) || (op == OP_BSRAV_RND);

  pshift_lanes #(.DATA_W(WORD_W), .LANE_W(BYTE_W), .ARITH(1'b1)) u_byte (
    .data(b), .shift(byte_sh), .round_en(byte_rnd), .data_out(byte_res)
  );

  pshift_lanes #(.DATA_W(WORD_W), .LANE_W(HALF_W), .ARITH(1'b0)) u_half (
    .data(b), .shift(half_sh), .round_en(1'b0), .data_out(half_res)
  );

  pshift_lanes #(.DATA_W(2*WORD_W), .LANE_W(WORD_W), .ARITH(1'b1)) u_word (
    .data({a, b}), .shift(shamt), .round_en(op == OP_PACK_RND), .data_out(word_res)
  );

  pshift_merge #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_merge (
    .a(a), .b(b), .amt(shamt),
    .repack_out(repack_res), .align_out(align_res),
    .append_out(append_res), .prepend_out(prepend_res)
  );

  // next-state select
  always_comb begin
    result_d = '0;
    case (op)
      OP_BSRA, OP_BSRA_RND, OP_BSRAV, OP_BSRAV_RND: result_d = byte_res;
      OP_HSRL, OP_HSRLV:                            result_d = half_res;
      OP_PACK, OP_PACK_RND: result_d = {word_res[WORD_W +: HALF_W], word_res[0 +: HALF_W]};
      OP_REPACK:  result_d = repack_res;
      OP_ALIGN:   result_d = align_res;
      OP_APPEND:  result_d = append_res;
      OP_PREPEND: result_d = prepend_res;
      default:    result_d = '0;
    endcase
  end

  // output register with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        result_q <= result_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R2
  AST_BYTE_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_BSRA && shamt[BSH_W-1:0] == '0) |=> (result == $past(b))); // R3
  AST_HALF_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_HSRL && shamt[HSH_W-1:0] != '0) |=> (!result[WORD_W-1] && !result[HALF_W-1])); // R5
  AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ALIGN && shamt[1:0] == 2'b00) |=> (result == $past(b))); // R8
  AST_PREPEND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_PREPEND && shamt == '0) |=> (result == $past(b))); // R10
  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 4'd12) |=> (result == '0)); // R11
endmodule

// File: tb/pshift_unit_tb.sv
`timescale 1ns/1ps
module pshift_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [4:0]  shamt;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  pshift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a(a), .b(b), .shamt(shamt), .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: {req 4, op 4, a 32, b 32, shamt 5, expected 32}
  localparam int NV = 21;
  localparam logic [108:0] VEC [NV] = '{
    {4'd3,  4'd0,  32'h00000000, 32'h807FF010, 5'd2,  32'hE01FFC04}, // R3 mixed signs
    {4'd4,  4'd1,  32'h00000000, 32'h807FF010, 5'd2,  32'hE020FC04}, // R4 one lane rounds
    {4'd4,  4'd3,  32'h0000000B, 32'hFF04857F, 5'd0,  32'h0001F110}, // R4 reg count 3, wrap to 00
    {4'd3,  4'd2,  32'hFFFFFFF8, 32'h12345678, 5'd5,  32'h12345678}, // R3 reg count masked to 0
    {4'd3,  4'd0,  32'h00000000, 32'h80017FFF, 5'd7,  32'hFF0000FF}, // R3 max count
    {4'd5,  4'd4,  32'h00000000, 32'h8001F0F0, 5'd20, 32'h08000F0F}, // R5 imm masked to 4
    {4'd5,  4'd5,  32'h0000001F, 32'hFFFF8000, 5'd0,  32'h00010001}, // R5 reg count 15
    {4'd6,  4'd6,  32'h12345678, 32'h80000000, 5'd8,  32'h34560000}, // R6 pack
    {4'd6,  4'd7,  32'h00001238, 32'hFFFFFFF7, 5'd4,  32'h0124FFFF}, // R6 pack rounding
    {4'd6,  4'd6,  32'hAAAA1111, 32'hBBBB2222, 5'd0,  32'h11112222}, // R6 zero count
    {4'd7,  4'd8,  32'h11223344, 32'h55667788, 5'd0,  32'h22446688}, // R7 repack
    {4'd8,  4'd9,  32'hAABBCCDD, 32'h11223344, 5'd1,  32'h223344AA}, // R8 p=1
    {4'd8,  4'd9,  32'hAABBCCDD, 32'h11223344, 5'd3,  32'h44AABBCC}, // R8 p=3
    {4'd8,  4'd9,  32'hAABBCCDD, 32'h11223344, 5'd4,  32'h11223344}, // R8 p=0
    {4'd9,  4'd10, 32'hFFFFFFAB, 32'h00123456, 5'd8,  32'h123456AB}, // R9 append
    {4'd9,  4'd10, 32'hFFFFFFAB, 32'h00123456, 5'd0,  32'h00123456}, // R9 zero
    {4'd10, 4'd11, 32'h000000CD, 32'h12345678, 5'd8,  32'hCD123456}, // R10 prepend
    {4'd10, 4'd11, 32'h000000CD, 32'h12345678, 5'd0,  32'h12345678}, // R10 zero
    {4'd10, 4'd11, 32'h00000003, 32'h80000000, 5'd31, 32'h00000007}, // R10 max count
    {4'd11, 4'd12, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3,  32'h00000000}, // R11
    {4'd11, 4'd15, 32'h12345678, 32'h9ABCDEF0, 5'd9,  32'h00000000}  // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp_v);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [31:0] va, input logic [31:0] vb,
                       input logic [4:0] s);
    in_valid = 1'b1; op = o; a = va; b = vb; shamt = s;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; a = '0; b = '0; shamt = '0;
    repeat (3) @(negedge clk);
    check("R2 reset valid", {31'd0, out_valid}, 32'd0);
    check("R2 reset result", result, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      issue(VEC[i][104:101], VEC[i][100:69], VEC[i][68:37], VEC[i][36:32]);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vector %0d", VEC[i][108:105], i), result, VEC[i][31:0]);
      check($sformatf("R1 valid vector %0d", i), {31'd0, out_valid}, 32'd1);
    end

    // R2: idle cycles with changing operands leave result alone
    @(negedge clk);
    issue(4'd8, 32'h11223344, 32'h55667788, 5'd0);
    @(negedge clk);
    in_valid = 1'b0; a = 32'hDEADBEEF; b = 32'hCAFEF00D; op = 4'd0;
    repeat (3) @(negedge clk);
    check("R2 hold result", result, 32'h22446688);
    check("R1 idle valid low", {31'd0, out_valid}, 32'd0);

    // R1: back-to-back operations
    @(negedge clk);
    issue(4'd9, 32'hAABBCCDD, 32'h11223344, 5'd2);
    @(negedge clk);
    check("R1 b2b first", result, 32'h3344AABB);
    issue(4'd10, 32'h0000000F, 32'h00000001, 5'd4);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 b2b second", result, 32'h0000001F);
    check("R1 b2b valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R1 valid drops", {31'd0, out_valid}, 32'd0);

    // R2: reset in mid-run clears the register
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 mid reset result", result, 32'd0);
    check("R2 mid reset valid", {31'd0, out_valid}, 32'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule